// File: doc/BRIEF.md
# Backplane Bus Requester with Release Policies

This block obtains backplane ownership on behalf of a card that holds two local masters: a processor path and a DMA engine. Each master raises a want line. The block picks one of them, with the processor ahead of the DMA engine. It drives one of four request lines at the level programmed for that master and waits for the grant. It then asserts bus-busy and tells the chosen master that it owns the bus. The master runs its data cycle and ends it with a one-cycle `xfer_done` pulse.

Ownership is given up according to a programmable release policy. The first policy keeps the bus parked after a transfer, so local masters can reuse it without arbitration, until any other request appears on the backplane. The second policy drops bus-busy as soon as the transfer ends. The third policy does the same and then, for fairness, holds back its next request while the request line at its level is still being driven by others. A bus-error timer, counted in 10 µs steps, ends a transfer that is never acknowledged. It raises an error flag and gives up the bus.

Top module: `vbus_requester`

## Requirements
- R1: After reset all request lines, bus-busy, both ownership outputs and the error flag are low. At most one request line is high at any time. While requesting, the high line is bit index equal to the 2-bit level of the master being served.
- R2: The processor is requested at `cpu_level` and the DMA engine at `dma_level`. Each uses its own setting.
- R3: When both masters want the bus while the block is idle, the processor is served first. The DMA request is raised only after the processor's ownership is released.
- R4: A grant seen while requesting makes bus-busy and the served master's ownership output high on the next cycle, with the request line dropped in that same cycle. The two ownership outputs are never high together.
- R5: With `rel_mode` = 1 (release when done), and also with code 3, bus-busy falls in the cycle after `xfer_done`.
- R6: With `rel_mode` = 0 (release on request), bus-busy stays high after `xfer_done`. It falls the cycle after any `bus_req_in` bit is seen high. While parked with no outside request, a local want is given ownership on the next cycle without raising a request line, again with the processor first.
- R7: With `rel_mode` = 2 (fair release), after a release the block raises no new request while `bus_req_in` at the candidate master's level is high. It requests in the cycle after that line is seen low.
- R8: If the owner has held the bus for `berr_steps` × `TICK_CYCLES` clock cycles without `xfer_done`, `berr_flag` is high for that one cycle and bus-busy falls on the next cycle. A `berr_steps` of 0 stands for 128 steps.
- R9: An `xfer_done` arriving in the very cycle the timer expires ends the transfer normally, and `berr_flag` stays low.
- R10: `bus_grant_in` has no effect unless a request line is being driven. A grant while idle leaves bus-busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_want | input | 1 | Processor path wants the bus (level, held until its transfer ends) |
| dma_want | input | 1 | DMA engine wants the bus (level, held until its transfer ends) |
| cpu_level | input | 2 | Request level for the processor path |
| dma_level | input | 2 | Request level for the DMA engine |
| rel_mode | input | 2 | Release policy: 0 on request, 1 when done, 2 when done with fairness, 3 as 1 |
| berr_steps | input | 7 | Bus-error timeout in steps of TICK_CYCLES cycles, 0 means 128 |
| bus_req_in | input | 4 | Request lines as driven by other cards |
| bus_grant_in | input | 1 | Incoming bus grant |
| xfer_done | input | 1 | One-cycle pulse: the current transfer was acknowledged and ended |
| bus_req_out | output | 4 | Request lines driven by this card |
| bus_busy | output | 1 | Bus-busy, high while this card owns the bus |
| cpu_owns | output | 1 | Processor path may run its transfer |
| dma_owns | output | 1 | DMA engine may run its transfer |
| berr_flag | output | 1 | Bus-error timeout, high for one cycle |

## Verification
The assertions assume that `rel_mode` stays constant while the bus is held. They also assume `xfer_done` pulses only while one of the ownership outputs is high. Last, they assume that a master drops its want no later than the cycle in which its `xfer_done` or `berr_flag` appears. The bench keeps within these rules: its model masters pulse done only while their ownership output is high, and they lower their want in that same cycle. It changes mode and level settings only while the block is idle with both wants low. Its model arbiter drives a grant only after a request line has been high for a few cycles, except in the one scenario that drives a stray grant on purpose.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_HOLD = 2'd2,
    ST_PARK = 2'd3
  } vbr_state_e;

  localparam logic [1:0] REL_ON_REQ = 2'd0;
  localparam logic [1:0] REL_DONE   = 2'd1;
  localparam logic [1:0] REL_FAIR   = 2'd2;

  localparam logic SRC_CPU = 1'b0;
  localparam logic SRC_DMA = 1'b1;
endpackage

// File: rtl/vbr_src_pick.sv
module vbr_src_pick #(
  parameter int LVL_W = 2
) (
  input  logic             cpu_want,
  input  logic             dma_want,
  input  logic [LVL_W-1:0] cpu_level,
  input  logic [LVL_W-1:0] dma_level,
  output logic             any_want,
  output logic             pick_dma,
  output logic [LVL_W-1:0] pick_level
);
  always_comb begin
    any_want   = cpu_want | dma_want;
    pick_dma   = ~cpu_want & dma_want;
    pick_level = pick_dma ? dma_level : cpu_level;
  end
endmodule

// File: rtl/vbr_fair_gate.sv
module vbr_fair_gate #(
  parameter int LINES = 4,
  localparam int LVL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fair_on,
  input  logic             set_hold,
  input  logic             clr_hold,
  input  logic [LINES-1:0] lines,
  input  logic [LVL_W-1:0] level,
  output logic             blocked
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    hold_d = hold_q;
    if (set_hold)      hold_d = 1'b1;
    else if (clr_hold) hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb blocked = fair_on & hold_q & lines[level];
endmodule

// File: rtl/vbr_berr_timer.sv
module vbr_berr_timer #(
  parameter int TICK_CYCLES = 2500,
  parameter int STEP_W      = 7,
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1,
  localparam int CNT_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W-1:0] steps,
  output logic              expire
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] stp_q, stp_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    if (steps == '0) limit = CNT_W'(1) << STEP_W;
    else             limit = {1'b0, steps};
  end

  always_comb begin
    pre_d = pre_q;
    stp_d = stp_q;
    if (!run) begin
      pre_d = '0;
      stp_d = '0;
    end else if (stp_q != limit) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        stp_d = stp_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      stp_q <= '0;
    end else begin
      pre_q <= pre_d;
      stp_q <= stp_d;
    end
  end

  always_comb expire = run & (stp_q == limit);
endmodule

// File: rtl/vbus_requester.sv
module vbus_requester
  import vbr_pkg::*;
#(
  parameter int LINES       = 4,
  parameter int STEP_W      = 7,
  parameter int TICK_CYCLES = 2500,
  localparam int LVL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_want,
  input  logic              dma_want,
  input  logic [LVL_W-1:0]  cpu_level,
  input  logic [LVL_W-1:0]  dma_level,
  input  logic [1:0]        rel_mode,
  input  logic [STEP_W-1:0] berr_steps,
  input  logic [LINES-1:0]  bus_req_in,
  input  logic              bus_grant_in,
  input  logic              xfer_done,
  output logic [LINES-1:0]  bus_req_out,
  output logic              bus_busy,
  output logic              cpu_owns,
  output logic              dma_owns,
  output logic              berr_flag
);
  vbr_state_e       st_q, st_d;
  logic             src_q, src_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             src_en, lvl_en;

  logic             any_want, pick_dma;
  logic [LVL_W-1:0] pick_level;
  logic             blocked, set_hold, clr_hold;
  logic             expire;
  logic             fair_on;

  assign fair_on = (rel_mode == REL_FAIR);

  vbr_src_pick #(.LVL_W(LVL_W)) u_pick (
    .cpu_want  (cpu_want),
    .dma_want  (dma_want),
    .cpu_level (cpu_level),
    .dma_level (dma_level),
    .any_want  (any_want),
    .pick_dma  (pick_dma),
    .pick_level(pick_level)
  );

  vbr_fair_gate #(.LINES(LINES)) u_fair (
    .clk     (clk),
    .rst_n   (rst_n),
    .fair_on (fair_on),
    .set_hold(set_hold),
    .clr_hold(clr_hold),
    .lines   (bus_req_in),
    .level   (pick_level),
    .blocked (blocked)
  );

  vbr_berr_timer #(.TICK_CYCLES(TICK_CYCLES), .STEP_W(STEP_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == ST_HOLD),
    .steps (berr_steps),
    .expire(expire)
  );

  // next-state process
  always_comb begin
    st_d     = st_q;
    src_d    = src_q;
    lvl_d    = lvl_q;
    src_en   = 1'b0;
    lvl_en   = 1'b0;
    set_hold = 1'b0;
    clr_hold = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (any_want && !blocked) begin
          st_d     = ST_ASK;
          src_d    = pick_dma;
          lvl_d    = pick_level;
          src_en   = 1'b1;
          lvl_en   = 1'b1;
          clr_hold = 1'b1;
        end
      end
      ST_ASK: begin
        if (bus_grant_in) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (xfer_done) begin
          if (rel_mode == REL_ON_REQ) begin
            st_d = ST_PARK;
          end else begin
            st_d     = ST_IDLE;
            set_hold = fair_on;
          end
        end else if (expire) begin
          st_d     = ST_IDLE;
          set_hold = fair_on;
        end
      end
      ST_PARK: begin
        if (|bus_req_in) begin
          st_d = ST_IDLE;
        end else if (cpu_want) begin
          st_d   = ST_HOLD;
          src_d  = SRC_CPU;
          src_en = 1'b1;
        end else if (dma_want) begin
          st_d   = ST_HOLD;
          src_d  = SRC_DMA;
          src_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      src_q <= SRC_CPU;
      lvl_q <= '0;
    end else begin
      st_q <= st_d;
      if (src_en) src_q <= src_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  // outputs
  for (genvar g = 0; g < LINES; g++) begin : g_req
    assign bus_req_out[g] = (st_q == ST_ASK) && (lvl_q == LVL_W'(g));
  end

  always_comb begin
    bus_busy  = (st_q == ST_HOLD) || (st_q == ST_PARK);
    cpu_owns  = (st_q == ST_HOLD) && (src_q == SRC_CPU);
    dma_owns  = (st_q == ST_HOLD) && (src_q == SRC_DMA);
    berr_flag = expire & ~xfer_done;
  end
endmodule

// File: rtl/vbr_checker.sv
module vbr_checker #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rel_mode,
  input logic             bus_grant_in,
  input logic             xfer_done,
  input logic [LINES-1:0] bus_req_out,
  input logic             bus_busy,
  input logic             cpu_owns,
  input logic             dma_owns,
  input logic             berr_flag
);
  assert_req_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_req_out));

  assert_grant_to_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_out != '0 && bus_grant_in) |=> (bus_busy && bus_req_out == '0));

  assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_owns && dma_owns));

  assert_req_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_out != '0) |-> !bus_busy);

  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_owns || dma_owns) && xfer_done && rel_mode[0]) |=> !bus_busy);

  assert_park_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_owns || dma_owns) && xfer_done && rel_mode == 2'd0) |=> bus_busy);

  assert_err_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    berr_flag |=> !bus_busy);

  assert_done_beats_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !berr_flag);
endmodule

bind vbus_requester vbr_checker #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rel_mode    (rel_mode),
  .bus_grant_in(bus_grant_in),
  .xfer_done   (xfer_done),
  .bus_req_out (bus_req_out),
  .bus_busy    (bus_busy),
  .cpu_owns    (cpu_owns),
  .dma_owns    (dma_owns),
  .berr_flag   (berr_flag)
);

// File: tb/vbus_requester_test.sv
`timescale 1ns/1ps
module vbus_requester_test;
  localparam int TICK = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_want = 1'b0, dma_want = 1'b0;
  logic [1:0] cpu_level = 2'd0, dma_level = 2'd0, rel_mode = 2'd1;
  logic [6:0] berr_steps = 7'd50;
  logic [3:0] bus_req_in = 4'd0;
  logic       bus_grant_in = 1'b0, xfer_done = 1'b0;
  logic [3:0] bus_req_out;
  logic       bus_busy, cpu_owns, dma_owns, berr_flag;

  always #2 clk = ~clk;

  vbus_requester #(.TICK_CYCLES(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_want(cpu_want), .dma_want(dma_want),
    .cpu_level(cpu_level), .dma_level(dma_level), .rel_mode(rel_mode),
    .berr_steps(berr_steps), .bus_req_in(bus_req_in), .bus_grant_in(bus_grant_in),
    .xfer_done(xfer_done), .bus_req_out(bus_req_out), .bus_busy(bus_busy),
    .cpu_owns(cpu_owns), .dma_owns(dma_owns), .berr_flag(berr_flag)
  );

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";
  int cpu_dur = 3, dma_dur = 3, cpu_cnt = 0, dma_cnt = 0, gwait = 0;
  bit stray_grant = 0;
  int err_seen = 0;

  // behavioural reference model: 0 idle, 1 asking, 2 holding, 3 parked
  int m_st = 0, m_src = 0, m_lvl = 0, m_hold = 0, m_cnt = 0;

  function automatic int lim_cycles();
    return ((berr_steps == 0) ? 128 : int'(berr_steps)) * TICK;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_src = 0; m_lvl = 0; m_hold = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (cpu_want || dma_want) begin
             int c, l;
             c = cpu_want ? 0 : 1;
             l = c ? int'(dma_level) : int'(cpu_level);
             if (!(rel_mode == 2 && m_hold != 0 && bus_req_in[l])) begin
               m_st = 1; m_src = c; m_lvl = l; m_hold = 0;
             end
           end
        1: if (bus_grant_in) begin m_st = 2; m_cnt = 0; end
        2: if (xfer_done) begin
             if (rel_mode == 0) m_st = 3;
             else begin m_st = 0; if (rel_mode == 2) m_hold = 1; end
           end else if (m_cnt == lim_cycles()) begin
             m_st = 0; if (rel_mode == 2) m_hold = 1;
           end else m_cnt++;
        default: if (bus_req_in != 0) m_st = 0;
                 else if (cpu_want) begin m_st = 2; m_src = 0; m_cnt = 0; end
                 else if (dma_want) begin m_st = 2; m_src = 1; m_cnt = 0; end
      endcase
    end
  end

  task automatic cmp(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    cmp("bus_req_out", int'(bus_req_out), (m_st == 1) ? (1 << m_lvl) : 0);
    cmp("bus_busy", int'(bus_busy), (m_st == 2 || m_st == 3) ? 1 : 0);
    cmp("cpu_owns", int'(cpu_owns), (m_st == 2 && m_src == 0) ? 1 : 0);
    cmp("dma_owns", int'(dma_owns), (m_st == 2 && m_src == 1) ? 1 : 0);
    cmp("berr_flag", int'(berr_flag),
        (m_st == 2 && m_cnt == lim_cycles() && !xfer_done) ? 1 : 0);
  endtask

  // one clock: react at the falling edge, then compare
  task automatic cyc();
    @(negedge clk);
    cycles++;
    if (bus_req_out != 0) gwait++; else gwait = 0;
    bus_grant_in = (gwait > 2) || (stray_grant && bus_req_out == 0);
    xfer_done = 1'b0;
    if (cpu_owns) begin
      cpu_cnt++;
      if (cpu_cnt >= cpu_dur) begin xfer_done = 1'b1; cpu_want = 1'b0; cpu_cnt = 0; end
    end
    if (dma_owns) begin
      dma_cnt++;
      if (dma_cnt >= dma_dur) begin xfer_done = 1'b1; dma_want = 1'b0; dma_cnt = 0; end
    end
    #0.5;
    compare_all();
    if (berr_flag) begin
      err_seen++;
      if (cpu_owns) begin cpu_want = 1'b0; cpu_cnt = 0; end
      if (dma_owns) begin dma_want = 1'b0; dma_cnt = 0; end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #1;
    tag = "R1";
    compare_all();
    cmp("reset outputs zero", int'({bus_req_out, bus_busy, cpu_owns, dma_owns, berr_flag}), 0);
    #20;
    @(negedge clk) rst_n = 1'b1;
    run(3);

    // R5: release when done, processor at level 2
    tag = "R5"; rel_mode = 2'd1; cpu_level = 2'd2; cpu_dur = 3;
    cpu_want = 1'b1; run(15);

    // R2/R3: both want, separate levels
    tag = "R3"; cpu_level = 2'd1; dma_level = 2'd3; dma_dur = 4;
    cpu_want = 1'b1; dma_want = 1'b1;
    cyc();
    cmp("R2 first request is processor level", int'(bus_req_out), 4'b0010);
    tag = "R2"; run(30);

    // R6: release on request with parking
    tag = "R6"; rel_mode = 2'd0; cpu_level = 2'd0; dma_level = 2'd2;
    cpu_want = 1'b1; run(12);
    cmp("R6 parked busy", int'(bus_busy), 1);
    dma_want = 1'b1; run(10);
    bus_req_in = 4'b1000; run(2);
    bus_req_in = 4'b0000;
    cmp("R6 released", int'(bus_busy), 0);
    run(4);

    // R7: fairness
    tag = "R7"; rel_mode = 2'd2; cpu_level = 2'd2;
    cpu_want = 1'b1; run(12);
    bus_req_in = 4'b0100; cpu_want = 1'b1; run(6);
    cmp("R7 request withheld", int'(bus_req_out), 0);
    bus_req_in = 4'b0001; run(12);
    bus_req_in = 4'b0000; run(4);

    // R8: timeout, then the 0 = 128 steps case
    tag = "R8"; rel_mode = 2'd1; berr_steps = 7'd2; cpu_dur = 100000; err_seen = 0;
    cpu_want = 1'b1; run(15);
    cmp("R8 one error pulse", err_seen, 1);
    berr_steps = 7'd0; err_seen = 0; dma_dur = 100000;
    dma_want = 1'b1; run(400);
    cmp("R8 one error pulse at 128 steps", err_seen, 1);

    // R9: done in the expiry cycle
    tag = "R9"; berr_steps = 7'd1; cpu_dur = 4; err_seen = 0;
    cpu_want = 1'b1; run(12);
    cmp("R9 no error", err_seen, 0);

    // R10: stray grant while idle, mode code 3
    tag = "R10"; stray_grant = 1; run(6);
    cmp("R10 busy stays low", int'(bus_busy), 0);
    stray_grant = 0; tag = "R5"; rel_mode = 2'd3; berr_steps = 7'd50; cpu_dur = 2;
    cpu_want = 1'b1; run(12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule